// File: doc/BRIEF.md
# Calibrated Energy Accumulator with Line-Cycle Capture

This block integrates a stream of signed instantaneous active-power samples into a 24-bit energy value. Once every four clock cycles it takes the sample on its power input and scales it by a signed 12-bit gain trim of the form (1 + gain/4096). It then adds a signed 16-bit offset whose low eight bits are fractional, and sums the result into a wide internal accumulator that keeps eight fractional bits. The visible energy is the integer part of that accumulator, divided by an 8-bit divider. A divider of zero means no division.

A one-cycle read-and-clear strobe lets the reader take the current energy and restart the integration in the same cycle. A second accumulator runs alongside the first and is gated by half line cycles. It counts zero-crossing pulses. When the programmed count of half cycles has elapsed, it latches its integer total into a line-cycle energy output and starts a new period. Single-cycle event pulses mark four conditions: the visible value passing half of full scale, the visible value wrapping, the end of a line period, and a change of sign in the power samples. An optional positive-only mode ignores samples of negative power.

Top module: `ecal_energy_acc`

## Requirements
- R1: While `rst` is high and in the cycle after it, `energy_o`, `line_energy_o` and all four event outputs are 0.
- R2: The accumulator changes only on update edges, which are every fourth rising clock edge. The first update is the fourth rising edge after `rst` goes low. `rd_clr_i` is the one exception.
- R3: Each update adds p·256 + floor(p·g/16) to the internal accumulator, in units of 1/256 of an energy LSB. Here p is `pwr_i` (signed) and g is `gain_i` (signed 12-bit). This equals p·(1 + g/4096) with eight fractional bits kept.
- R4: Each update also adds `ofs_i` (signed 16-bit) in units of 1/256 of an energy LSB.
- R5: The internal accumulator is 40 bits wide and wraps. `energy_o` is bits 23:0 of the quotient, rounded toward zero, of the signed 32-bit integer part (accumulator bits 39:8) divided by D. D is `div_i`, or 1 when `div_i` is 0.
- R6: While `rd_clr_i` is high, `energy_o` still shows the current value. At that edge the accumulator is loaded with 0, or with that edge's increment when the edge is also an update edge.
- R7: With `pos_only_i` high, an update whose sample is negative leaves the accumulator unchanged. The offset is not added on that update either.
- R8: `evt_half_o` pulses for one cycle when the top two bits of `energy_o` go from 00 to 01 or from 11 to 10 between consecutive cycles.
- R9: `evt_ovf_o` pulses for one cycle when the top two bits of `energy_o` go from 01 to 10 or from 10 to 01 between consecutive cycles.
- R10: `evt_sign_o` pulses in the cycle after an update edge whose sample sign differs from the sign at the previous update. The sign before the first update counts as positive.
- R11: `zc_i` pulses are counted. On the pulse that brings the count to the target (`lcyc_i`, with 0 treated as 1), three things happen. First, `line_energy_o` takes the line accumulator's integer part divided as in R5, without that edge's increment. Second, the count returns to 0 and the line accumulator restarts with that edge's increment, if that edge is an update edge. Third, `evt_lcyc_o` pulses in the next cycle.
- R12: `rd_clr_i` has no effect on the line accumulator, the half-cycle count or `line_energy_o`, and `line_energy_o` changes only on the pulse that ends a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_i | input | PWR_W | Signed instantaneous power sample |
| gain_i | input | 12 | Signed gain trim, weight 2^-12 |
| ofs_i | input | 16 | Signed offset per update, 8 fractional bits |
| div_i | input | 8 | Output divider, 0 means no division |
| pos_only_i | input | 1 | Ignore negative samples |
| zc_i | input | 1 | One-cycle zero-crossing pulse |
| lcyc_i | input | LCYC_W | Half line cycles per line period |
| rd_clr_i | input | 1 | Read-and-clear strobe |
| energy_o | output | 24 | Divided integer energy |
| line_energy_o | output | 24 | Energy latched at end of line period |
| evt_half_o | output | 1 | Half-scale crossing pulse |
| evt_ovf_o | output | 1 | Wrap pulse |
| evt_lcyc_o | output | 1 | End of line period pulse |
| evt_sign_o | output | 1 | Power sign change pulse |

## Verification
A wrong accumulator state shows on `energy_o` in the cycle right after the update edge that caused it, because the divided value is formed without a register. A wrong sign or half-cycle counter state shows one edge later, as a missing or misplaced event pulse. A wrong line accumulator stays hidden until the pulse that ends the period, and then it appears in `line_energy_o`. The bench therefore compares every output in every cycle against an arithmetic model. It also ends several line periods within each configuration, so that line-accumulator errors surface.

// File: rtl/ecal_pkg.sv
package ecal_pkg;

    localparam int ENERGY_W = 24;
    localparam int FRAC_W   = 8;
    localparam int DIV_W    = 8;
    localparam int GAIN_W   = 12;
    localparam int OFS_W    = 16;
    localparam int ACC_W    = ENERGY_W + DIV_W + FRAC_W;
    localparam int IP_W     = ACC_W - FRAC_W;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [ENERGY_W-1:0]     energy_t;

    // top two bits of the visible value
    typedef enum logic [1:0] {
        Z_LOW_POS  = 2'b00,
        Z_HIGH_POS = 2'b01,
        Z_HIGH_NEG = 2'b10,
        Z_LOW_NEG  = 2'b11
    } zone_e;

    typedef struct packed {
        logic half;
        logic ovf;
    } level_evt_t;

    // integer part divided by the divider, truncated toward zero
    function automatic energy_t scale_out(acc_t a, logic [DIV_W-1:0] d);
        logic signed [IP_W-1:0] ip;
        logic signed [IP_W-1:0] dd;
        logic signed [IP_W-1:0] q;
        ip = a[ACC_W-1:FRAC_W];
        dd = (d == '0) ? IP_W'(1) : IP_W'(d);
        q  = ip / dd;
        return q[ENERGY_W-1:0];
    endfunction

    function automatic zone_e zone_of(energy_t e);
        return zone_e'(e[ENERGY_W-1 -: 2]);
    endfunction

    function automatic level_evt_t level_events(zone_e p, zone_e c);
        level_evt_t r;
        r.half = (p == Z_LOW_POS  && c == Z_HIGH_POS) ||
                 (p == Z_LOW_NEG  && c == Z_HIGH_NEG);
        r.ovf  = (p == Z_HIGH_POS && c == Z_HIGH_NEG) ||
                 (p == Z_HIGH_NEG && c == Z_HIGH_POS);
        return r;
    endfunction

endpackage

// File: rtl/ecal_tick.sv
module ecal_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/ecal_scale.sv
module ecal_scale
    import ecal_pkg::*;
#(
    parameter int PWR_W = 24
) (
    input  logic signed [PWR_W-1:0]  pwr_i,
    input  logic signed [GAIN_W-1:0] gain_i,
    input  logic signed [OFS_W-1:0]  ofs_i,
    input  logic                     pos_only_i,
    output acc_t                     inc_o,
    output logic                     neg_o
);
    localparam int PROD_W = PWR_W + GAIN_W;
    localparam int SHIFT  = GAIN_W - FRAC_W;

    logic signed [PROD_W-1:0] prod;
    acc_t base, trim, bias;

    always_comb begin
        prod  = PROD_W'(pwr_i) * PROD_W'(gain_i);
        base  = acc_t'(pwr_i) <<< FRAC_W;
        trim  = acc_t'(prod >>> SHIFT);
        bias  = acc_t'(ofs_i);
        neg_o = pwr_i[PWR_W-1];
        inc_o = (pos_only_i && neg_o) ? '0 : base + trim + bias;
    end
endmodule

// File: rtl/ecal_acc.sv
module ecal_acc
    import ecal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  acc_t             inc_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output acc_t             acc_o,
    output energy_t          energy_o,
    output logic             evt_half_o,
    output logic             evt_ovf_o
);
    acc_t       acc_q;
    energy_t    vis, vis_q;
    level_evt_t lv;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            vis_q <= '0;
        end else begin
            vis_q <= vis;
            if (clr_i)       acc_q <= tick_i ? inc_i : '0;
            else if (tick_i) acc_q <= acc_q + inc_i;
        end
    end

    always_comb begin
        vis = scale_out(acc_q, div_i);
        lv  = level_events(zone_of(vis_q), zone_of(vis));
    end

    assign acc_o      = acc_q;
    assign energy_o   = vis;
    assign evt_half_o = lv.half;
    assign evt_ovf_o  = lv.ovf;
endmodule

// File: rtl/ecal_linecyc.sv
module ecal_linecyc
    import ecal_pkg::*;
#(
    parameter int LCYC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  acc_t              inc_i,
    input  logic              zc_i,
    input  logic [LCYC_W-1:0] lcyc_i,
    input  logic [DIV_W-1:0]  div_i,
    output energy_t           line_energy_o,
    output logic              evt_lcyc_o
);
    logic [LCYC_W-1:0] hc;
    logic [LCYC_W:0]   hc_next, target;
    logic              period_end;
    acc_t              lacc;
    energy_t           line_q;
    logic              evt_q;

    always_comb begin
        hc_next    = {1'b0, hc} + (LCYC_W+1)'(1);
        target     = (lcyc_i == '0) ? (LCYC_W+1)'(1) : {1'b0, lcyc_i};
        period_end = zc_i && (hc_next >= target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc     <= '0;
            lacc   <= '0;
            line_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= period_end;
            if (period_end) begin
                hc     <= '0;
                line_q <= scale_out(lacc, div_i);
                lacc   <= tick_i ? inc_i : '0;
            end else begin
                if (zc_i)   hc   <= hc_next[LCYC_W-1:0];
                if (tick_i) lacc <= lacc + inc_i;
            end
        end
    end

    assign line_energy_o = line_q;
    assign evt_lcyc_o    = evt_q;
endmodule

// File: rtl/ecal_energy_acc.sv
module ecal_energy_acc
    import ecal_pkg::*;
#(
    parameter int PWR_W    = 24,
    parameter int LCYC_W   = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [PWR_W-1:0]  pwr_i,
    input  logic signed [GAIN_W-1:0] gain_i,
    input  logic signed [OFS_W-1:0]  ofs_i,
    input  logic [DIV_W-1:0]         div_i,
    input  logic                     pos_only_i,
    input  logic                     zc_i,
    input  logic [LCYC_W-1:0]        lcyc_i,
    input  logic                     rd_clr_i,
    output logic [ENERGY_W-1:0]      energy_o,
    output logic [ENERGY_W-1:0]      line_energy_o,
    output logic                     evt_half_o,
    output logic                     evt_ovf_o,
    output logic                     evt_lcyc_o,
    output logic                     evt_sign_o
);
    logic upd_tick;
    acc_t inc;
    logic inc_neg;
    acc_t acc_int;
    logic last_neg;
    logic sign_q;

    ecal_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(upd_tick)
    );

    ecal_scale #(.PWR_W(PWR_W)) u_scale (
        .pwr_i(pwr_i), .gain_i(gain_i), .ofs_i(ofs_i),
        .pos_only_i(pos_only_i), .inc_o(inc), .neg_o(inc_neg)
    );

    ecal_acc u_acc (
        .clk(clk), .rst(rst), .tick_i(upd_tick), .inc_i(inc),
        .clr_i(rd_clr_i), .div_i(div_i), .acc_o(acc_int),
        .energy_o(energy_o), .evt_half_o(evt_half_o), .evt_ovf_o(evt_ovf_o)
    );

    ecal_linecyc #(.LCYC_W(LCYC_W)) u_line (
        .clk(clk), .rst(rst), .tick_i(upd_tick), .inc_i(inc),
        .zc_i(zc_i), .lcyc_i(lcyc_i), .div_i(div_i),
        .line_energy_o(line_energy_o), .evt_lcyc_o(evt_lcyc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_neg <= 1'b0;
            sign_q   <= 1'b0;
        end else begin
            sign_q <= upd_tick && (inc_neg != last_neg);
            if (upd_tick) last_neg <= inc_neg;
        end
    end

    assign evt_sign_o = sign_q;
endmodule

// File: rtl/ecal_energy_chk.sv
module ecal_energy_chk
    import ecal_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    tick,
    input logic    rd_clr_i,
    input logic    pos_only_i,
    input logic    pwr_neg,
    input logic    zc_i,
    input acc_t    acc_val,
    input energy_t energy_o,
    input energy_t line_energy_o,
    input logic    evt_half_o,
    input logic    evt_ovf_o,
    input logic    evt_lcyc_o,
    input logic    evt_sign_o
);
    a_r2_hold_between_updates: assert property (@(posedge clk) disable iff (rst)
        (!tick && !rd_clr_i) |=> $stable(acc_val));

    a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !tick) |=> (energy_o == '0));

    a_r7_negative_skipped: assert property (@(posedge clk) disable iff (rst)
        (pos_only_i && tick && pwr_neg && !rd_clr_i) |=> $stable(acc_val));

    // R8 and R9 mark disjoint transitions
    a_r9_level_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_half_o, evt_ovf_o}));

    a_r10_sign_after_update: assert property (@(posedge clk) disable iff (rst)
        evt_sign_o |-> $past(tick));

    a_r11_period_after_zc: assert property (@(posedge clk) disable iff (rst)
        evt_lcyc_o |-> $past(zc_i));

    a_r12_line_holds: assert property (@(posedge clk) disable iff (rst)
        !zc_i |=> $stable(line_energy_o));
endmodule

bind ecal_energy_acc ecal_energy_chk u_chk (
    .clk(clk), .rst(rst), .tick(upd_tick), .rd_clr_i(rd_clr_i),
    .pos_only_i(pos_only_i), .pwr_neg(inc_neg), .zc_i(zc_i),
    .acc_val(acc_int), .energy_o(energy_o), .line_energy_o(line_energy_o),
    .evt_half_o(evt_half_o), .evt_ovf_o(evt_ovf_o),
    .evt_lcyc_o(evt_lcyc_o), .evt_sign_o(evt_sign_o)
);

// File: tb/ecal_energy_acc_bench.sv
module ecal_energy_acc_bench;
    import ecal_pkg::*;

    localparam int PWR_W  = 24;
    localparam int LCYC_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [PWR_W-1:0]  pwr = '0;
    logic signed [GAIN_W-1:0] gain = '0;
    logic signed [OFS_W-1:0]  ofs = '0;
    logic [DIV_W-1:0]         dv = '0;
    logic                     pos_only = 1'b0;
    logic                     zc = 1'b0;
    logic [LCYC_W-1:0]        lcyc = 16'hFFFF;
    logic                     rd_clr = 1'b0;
    logic [ENERGY_W-1:0]      energy, line_energy;
    logic                     e_half, e_ovf, e_lcyc, e_sign;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecal_energy_acc #(.PWR_W(PWR_W), .LCYC_W(LCYC_W), .TICK_DIV(4)) u_ecal_energy_acc (
        .clk(clk), .rst(rst), .pwr_i(pwr), .gain_i(gain), .ofs_i(ofs),
        .div_i(dv), .pos_only_i(pos_only), .zc_i(zc), .lcyc_i(lcyc),
        .rd_clr_i(rd_clr), .energy_o(energy), .line_energy_o(line_energy),
        .evt_half_o(e_half), .evt_ovf_o(e_ovf), .evt_lcyc_o(e_lcyc),
        .evt_sign_o(e_sign)
    );

    // reference model state
    acc_t    macc = '0, mlacc = '0;
    int      mcnt = 0, mhc = 0;
    energy_t mline = '0, mvisq = '0;
    bit      mlastneg = 0, mevt_sign = 0, mevt_lcyc = 0;

    function automatic energy_t bvis(acc_t a, int d);
        longint ip, q;
        ip = longint'($signed(a[ACC_W-1:FRAC_W]));
        q  = ip / longint'((d == 0) ? 1 : d);
        return q[ENERGY_W-1:0];
    endfunction

    function automatic longint binc();
        longint p, prod;
        p = longint'(pwr);
        if (pos_only && p < 0) return 0;
        prod = p * longint'(gain);
        return p * 256 + (prod >>> 4) + longint'(ofs);
    endfunction

    task automatic model_step();
        bit tk, endp, neg;
        longint inc;
        int tgt;
        if (rst) begin
            macc = '0; mlacc = '0; mcnt = 0; mhc = 0; mline = '0; mvisq = '0;
            mlastneg = 0; mevt_sign = 0; mevt_lcyc = 0;
            return;
        end
        tk   = (mcnt == 3);
        mcnt = (mcnt + 1) % 4;
        inc  = binc();
        neg  = pwr < 0;
        tgt  = (lcyc == 0) ? 1 : int'(lcyc);
        endp = zc && (mhc + 1 >= tgt);
        mvisq = bvis(macc, int'(dv));
        if (endp) begin
            mline = bvis(mlacc, int'(dv));
            mlacc = tk ? acc_t'(inc) : '0;
            mhc   = 0;
        end else begin
            if (tk) mlacc = acc_t'(longint'(mlacc) + inc);
            if (zc) mhc++;
        end
        mevt_lcyc = endp;
        if (rd_clr) macc = tk ? acc_t'(inc) : '0;
        else if (tk) macc = acc_t'(longint'(macc) + inc);
        mevt_sign = tk && (neg != mlastneg);
        if (tk) mlastneg = neg;
    endtask

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        energy_t ev;
        bit xh, xo;
        logic [1:0] zp, zn;
        ev = bvis(macc, int'(dv));
        zp = mvisq[ENERGY_W-1 -: 2];
        zn = ev[ENERGY_W-1 -: 2];
        xh = (zp == 2'b00 && zn == 2'b01) || (zp == 2'b11 && zn == 2'b10);
        xo = (zp == 2'b01 && zn == 2'b10) || (zp == 2'b10 && zn == 2'b01);
        chk(tag, "energy", longint'(energy), longint'(ev));
        chk(tag, "line_energy", longint'(line_energy), longint'(mline));
        chk(tag, "evt_half", longint'(e_half), longint'(xh));
        chk(tag, "evt_ovf", longint'(e_ovf), longint'(xo));
        chk(tag, "evt_lcyc", longint'(e_lcyc), longint'(mevt_lcyc));
        chk(tag, "evt_sign", longint'(e_sign), longint'(mevt_sign));
    endtask

    task automatic run(int n, string tag, int zc_every, int clr_every);
        for (int i = 0; i < n; i++) begin
            zc     = (zc_every  != 0) && (i % zc_every  == zc_every  - 1);
            rd_clr = (clr_every != 0) && (i % clr_every == clr_every - 1);
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare(tag);
        end
        zc = 1'b0;
        rd_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(2, "R1", 0, 0);
        rst = 1'b0;
    endtask

    initial begin
        automatic int gains[7]  = '{-2048, -1000, -1, 0, 1, 777, 2047};
        automatic int pwrs[6]   = '{1, -1, 12345, -12345, 8388607, -8388608};
        automatic int divs[7]   = '{0, 1, 2, 3, 7, 128, 255};
        automatic int dpwrs[3]  = '{999, -999, 123456};

        // R1: reset state
        run(3, "R1", 0, 0);
        rst = 1'b0;
        run(1, "R1", 0, 0);

        // R2: update cadence from reset release
        do_reset();
        pwr = 24'sd5;
        run(14, "R2", 0, 0);

        // R3: gain sweep
        foreach (gains[gi]) begin
            foreach (pwrs[pi]) begin
                gain = GAIN_W'(gains[gi]);
                pwr  = PWR_W'(pwrs[pi]);
                do_reset();
                run(20, "R3", 0, 0);
            end
        end
        gain = '0;

        // R4: fractional offset, including a full carry into the integer part
        pwr = '0;
        ofs = 16'sd1;   do_reset(); run(1030, "R4", 0, 0);
        ofs = -16'sd1;  do_reset(); run(40, "R4", 0, 0);
        ofs = 16'sd300; do_reset(); run(40, "R4", 0, 0);
        ofs = -16'sd32768; pwr = 24'sd100; do_reset(); run(40, "R4", 0, 0);
        ofs = '0;

        // R5: divider sweep
        foreach (divs[di]) begin
            foreach (dpwrs[pi]) begin
                dv  = DIV_W'(divs[di]);
                pwr = PWR_W'(dpwrs[pi]);
                ofs = 16'sd37;
                do_reset();
                run(24, "R5", 0, 0);
            end
        end
        dv = '0; ofs = '0;

        // R6: read-and-clear off and on update edges
        pwr = 24'sd300;
        do_reset(); run(40, "R6", 0, 5);
        do_reset(); run(40, "R6", 0, 7);
        dv = 8'd3; do_reset(); run(40, "R6", 0, 4);
        dv = '0;

        // R7: positive-only mode
        pos_only = 1'b1; ofs = 16'sd50;
        pwr = -24'sd500; do_reset(); run(24, "R7", 0, 0);
        pwr = 24'sd500; run(16, "R7", 0, 0);
        pwr = -24'sd500; run(16, "R7", 0, 0);
        pos_only = 1'b0; ofs = '0;

        // R8 / R9: half-scale and wrap in both directions
        pwr = 24'sd2097152; do_reset();
        run(10, "R8", 0, 0); run(30, "R9", 0, 0);
        pwr = -24'sd2097152; do_reset();
        run(10, "R8", 0, 0); run(30, "R9", 0, 0);
        pwr = 24'sd1048576; dv = 8'd2; do_reset();
        run(40, "R8", 0, 0);
        dv = '0;

        // R10: sign changes
        do_reset();
        for (int k = 0; k < 6; k++) begin
            pwr = (k % 2 == 0) ? -24'sd77 : 24'sd77;
            run(8, "R10", 0, 0);
        end
        pwr = -24'sd5; run(3, "R10", 0, 0);
        pwr = 24'sd5;  run(9, "R10", 0, 0);

        // R11: line periods with several counts and dividers
        pwr = 24'sd1000;
        lcyc = 16'd3; do_reset(); run(120, "R11", 6, 0);
        lcyc = 16'd1; do_reset(); run(60, "R11", 5, 0);
        lcyc = 16'd0; do_reset(); run(60, "R11", 7, 0);
        lcyc = 16'd2; dv = 8'd5; gain = 12'sd500; do_reset(); run(120, "R11", 4, 0);
        dv = '0; gain = '0;

        // R12: read-and-clear leaves the line path alone
        lcyc = 16'd4; do_reset(); run(160, "R12", 6, 3);
        lcyc = 16'hFFFF; do_reset(); run(40, "R12", 5, 2);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule